// File: doc/BRIEF.md
# Prioritised Memory Protection Region Checker

This block decides, for every memory access a processor issues, whether the access is allowed and which memory attributes apply to it. A small set of protection regions is held in flops. Each region has a base address, a power-of-two size of at least 32 bytes, an enable flag, four permission bits and three attribute bits. Every access address is compared against all regions in parallel. When several regions cover the same address, the one with the highest index decides the outcome, so a small region with a high index can carve an exception out of a large region with a low index.

The result comes out registered one cycle after the access is presented. It has two fault flags: one for an address that no enabled region covers, and one for an access that the winning region does not permit. It also reports the index of the winning region and its attributes (cacheable, write-back versus write-through, shareable). The next level of the memory system uses these attributes to decide how to handle the access. Software programs a region by writing one 40-bit configuration word to a region index.

Top module: `prot_region_checker`

## Requirements
- R1: After synchronous reset, every region is disabled and `res_valid` is low. The first access after reset therefore raises the background fault.
- R2: A result appears exactly one clock after `acc_valid` is sampled high, with `res_valid` high for that one cycle. A cycle with `acc_valid` low produces `res_valid` low on the next cycle.
- R3: A write with `cfg_we` high stores `cfg_data` into region `cfg_idx` at the clock edge. An access sampled on the same edge still sees the old contents. A write whose index is NUM_REGIONS or above is ignored.
- R4: The configuration word has these fields: bits [31:5] are the base, bits [4:0] are the size code s, bit 32 is enable, bit 33 allows privileged write, bit 34 allows user read, bit 35 allows user write, bit 36 forbids execution, bit 37 is cacheable, bit 38 selects write-back (0 means write-through), and bit 39 is shareable. An enabled region covers the aligned block of 2^(s+5) bytes that contains its base. Base bits below the size are ignored. A size code of 27 or above covers the whole 32-bit space.
- R5: When more than one enabled region covers the address, the region with the highest index wins. A disabled region never matches.
- R6: If no enabled region matches, `res_bg_fault` is high, and `res_hit`, `res_perm_fault`, `res_region` and all three attribute outputs are zero.
- R7: The access kind is encoded as 0 for read, 1 for write, 2 for execute, and 3 is treated as read. A privileged read is always allowed. A user read needs the user-read bit. A write needs the privileged-write bit or the user-write bit, depending on `acc_priv`. A denied access sets `res_perm_fault`.
- R8: An execute access faults if the winning region forbids execution. Otherwise it follows the read rule.
- R9: On a hit, `res_region` is the index of the winning region, and the attribute outputs are that region's attribute bits.
- R10: NUM_REGIONS is 8 or 12, and every region index in that range behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_idx | input | IDX_W | Region index to write |
| cfg_data | input | 40 | Region configuration word (fields in R4) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| acc_priv | input | 1 | Access is privileged |
| res_valid | output | 1 | Result valid (one cycle after the access) |
| res_hit | output | 1 | Some enabled region matched |
| res_region | output | IDX_W | Winning region index |
| res_perm_fault | output | 1 | Winning region denies the access |
| res_bg_fault | output | 1 | No enabled region matched |
| res_cacheable | output | 1 | Winning region is cacheable |
| res_write_back | output | 1 | Write-back when high, write-through when low |
| res_shareable | output | 1 | Winning region is shareable |

## Verification
The assertions run on every cycle. They check that a result follows each access by exactly one cycle and that a reset clears the result. They also check that a reported winner was an enabled region when the access was sampled, that a forbidden execute always faults and a privileged read never does, and that a background fault forces zero attributes and no hit. The bench scenarios are the only place that shows which region wins an overlap, where the aligned block edges lie (including the 32-byte and whole-space sizes), that out-of-range writes are ignored and same-edge writes are not yet visible, and that every permission combination produces the right fault.

// File: rtl/prc_pkg.sv
package prc_pkg;

  localparam int ADDR_W    = 32;
  localparam int MIN_SHIFT = 5;
  localparam int SIZE_W    = 5;
  localparam int CFG_W     = 40;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic shareable;
    logic write_back;
    logic cacheable;
  } mem_attr_t;

  typedef struct packed {
    logic no_exec;
    logic user_wr;
    logic user_rd;
    logic priv_wr;
  } perm_t;

  // Packed layout, MSB first, fixes the configuration word bit positions.
  typedef struct packed {
    mem_attr_t                  attr;
    perm_t                      perm;
    logic                       enable;
    logic [ADDR_W-1:MIN_SHIFT]  base_hi;
    logic [SIZE_W-1:0]          size_code;
  } region_cfg_t;

  // Address bits that must agree with the base for a region of code s.
  function automatic logic [ADDR_W-1:0] size_mask(input logic [SIZE_W-1:0] code);
    logic [ADDR_W:0] span;
    logic [ADDR_W:0] low;
    span = (ADDR_W+1)'(1) << ({1'b0, code} + (SIZE_W+1)'(MIN_SHIFT));
    low  = span - (ADDR_W+1)'(1);
    return ~low[ADDR_W-1:0];
  endfunction

  function automatic logic perm_denied(input perm_t p, input acc_kind_e k, input logic priv);
    logic deny;
    case (k)
      ACC_WRITE: deny = priv ? !p.priv_wr : !p.user_wr;
      ACC_EXEC:  deny = p.no_exec || (!priv && !p.user_rd);
      default:   deny = !priv && !p.user_rd;
    endcase
    return deny;
  endfunction

endpackage

// File: rtl/prc_region_file.sv
module prc_region_file #(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  prc_pkg::region_cfg_t    wr_data,
  output prc_pkg::region_cfg_t    regions [NUM_REGIONS]
);

  // One register per region; indices beyond the count decode to nothing.
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        regions[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        regions[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/prc_region_match.sv
module prc_region_match #(
  parameter int NUM_REGIONS = 8
) (
  input  logic [prc_pkg::ADDR_W-1:0]  addr,
  input  prc_pkg::region_cfg_t        regions [NUM_REGIONS],
  output logic [NUM_REGIONS-1:0]      hit_vec
);

  localparam int AW = prc_pkg::ADDR_W;
  localparam int LS = prc_pkg::MIN_SHIFT;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic [AW-1:0] mask;
    logic [AW-1:0] base;
    always_comb begin
      mask       = prc_pkg::size_mask(regions[g].size_code);
      base       = {regions[g].base_hi, {LS{1'b0}}};
      hit_vec[g] = regions[g].enable && ((addr & mask) == (base & mask));
    end
  end

endmodule

// File: rtl/prc_priority_sel.sv
module prc_priority_sel #(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_REGIONS-1:0] hit_vec,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       win_idx
);

  // Ascending scan: a later (higher) match overrides an earlier one.
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker #(
  parameter  int NUM_REGIONS = 8,
  localparam int IDX_W       = $clog2(NUM_REGIONS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [39:0]        cfg_data,
  input  logic               acc_valid,
  input  logic [31:0]        acc_addr,
  input  logic [1:0]         acc_kind,
  input  logic               acc_priv,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_region,
  output logic               res_perm_fault,
  output logic               res_bg_fault,
  output logic               res_cacheable,
  output logic               res_write_back,
  output logic               res_shareable
);

  prc_pkg::region_cfg_t regions [NUM_REGIONS];
  prc_pkg::region_cfg_t win;
  logic [NUM_REGIONS-1:0] hit_vec;
  logic                   any_hit;
  logic [IDX_W-1:0]       win_idx;
  logic                   deny;

  prc_region_file #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_file (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (prc_pkg::region_cfg_t'(cfg_data)),
    .regions (regions)
  );

  prc_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .addr    (acc_addr),
    .regions (regions),
    .hit_vec (hit_vec)
  );

  prc_priority_sel #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  always_comb begin
    win  = regions[win_idx];
    deny = prc_pkg::perm_denied(win.perm, prc_pkg::acc_kind_e'(acc_kind), acc_priv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_hit        <= 1'b0;
      res_region     <= '0;
      res_perm_fault <= 1'b0;
      res_bg_fault   <= 1'b0;
      res_cacheable  <= 1'b0;
      res_write_back <= 1'b0;
      res_shareable  <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_hit        <= any_hit;
        res_region     <= any_hit ? win_idx : '0;
        res_perm_fault <= any_hit && deny;
        res_bg_fault   <= !any_hit;
        res_cacheable  <= any_hit && win.attr.cacheable;
        res_write_back <= any_hit && win.attr.write_back;
        res_shareable  <= any_hit && win.attr.shareable;
      end
    end
  end

endmodule

// File: rtl/prc_sva.sv
module prc_sva #(
  parameter  int NUM_REGIONS = 8,
  localparam int IDX_W       = $clog2(NUM_REGIONS)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_idx,
  input logic [39:0]      cfg_data,
  input logic             acc_valid,
  input logic [1:0]       acc_kind,
  input logic             acc_priv,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_region,
  input logic             res_perm_fault,
  input logic             res_bg_fault,
  input logic             res_cacheable,
  input logic             res_write_back,
  input logic             res_shareable
);

  logic [NUM_REGIONS-1:0] sh_en, sh_nx, prev_en, prev_nx;
  logic [1:0]             prev_kind;
  logic                   prev_priv;

  // Shadow of enable and execute-forbid bits, taken from the write port.
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_sh
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_en[g] <= 1'b0;
        sh_nx[g] <= 1'b0;
      end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
        sh_en[g] <= cfg_data[32];
        sh_nx[g] <= cfg_data[36];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en   <= '0;
      prev_nx   <= '0;
      prev_kind <= 2'd0;
      prev_priv <= 1'b0;
    end else begin
      prev_en   <= sh_en;
      prev_nx   <= sh_nx;
      prev_kind <= acc_kind;
      prev_priv <= acc_priv;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !res_valid);

  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid);

  a_r5_winner_enabled: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> prev_en[res_region]);

  a_r6_miss_clean: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_bg_fault) |->
      (!res_hit && !res_perm_fault && !res_cacheable && !res_write_back && !res_shareable));

  a_r6_hit_or_bg: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_hit, res_bg_fault}));

  a_r7_priv_read_ok: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit && prev_priv && (prev_kind == 2'd0 || prev_kind == 2'd3))
      |-> !res_perm_fault);

  a_r8_exec_forbidden: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit && prev_kind == 2'd2 && prev_nx[res_region]) |-> res_perm_fault);

endmodule

bind prot_region_checker prc_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (
  .clk            (clk),
  .rst            (rst),
  .cfg_we         (cfg_we),
  .cfg_idx        (cfg_idx),
  .cfg_data       (cfg_data),
  .acc_valid      (acc_valid),
  .acc_kind       (acc_kind),
  .acc_priv       (acc_priv),
  .res_valid      (res_valid),
  .res_hit        (res_hit),
  .res_region     (res_region),
  .res_perm_fault (res_perm_fault),
  .res_bg_fault   (res_bg_fault),
  .res_cacheable  (res_cacheable),
  .res_write_back (res_write_back),
  .res_shareable  (res_shareable)
);

// File: tb/sim_prot_region_checker.sv
module sim_prot_region_checker;

  localparam int NR = 12;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [39:0]   cfg_data = '0;
  logic          acc_valid = 1'b0;
  logic [31:0]   acc_addr = '0;
  logic [1:0]    acc_kind = '0;
  logic          acc_priv = 1'b0;
  logic          res_valid, res_hit, res_perm_fault, res_bg_fault;
  logic          res_cacheable, res_write_back, res_shareable;
  logic [IW-1:0] res_region;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [39:0] m_cfg [NR];

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
    logic          pf;
    logic          bg;
    logic          c;
    logic          wb;
    logic          sh;
  } exp_t;

  always #2.5 clk = ~clk;

  prot_region_checker #(.NUM_REGIONS(NR)) u0 (
    .clk, .rst, .cfg_we, .cfg_idx, .cfg_data, .acc_valid, .acc_addr, .acc_kind,
    .acc_priv, .res_valid, .res_hit, .res_region, .res_perm_fault, .res_bg_fault,
    .res_cacheable, .res_write_back, .res_shareable
  );

  // Config word builder: fields as listed in R4.
  function automatic logic [39:0] mk(input logic [31:0] base, input logic [4:0] sz,
                                     input logic en, input logic [3:0] perm, input logic [2:0] attr);
    return {attr, perm, en, base[31:5], sz};
  endfunction

  function automatic exp_t model(input logic [31:0] a, input logic [1:0] k, input logic p);
    exp_t e = '0;
    e.bg = 1'b1;
    for (int i = 0; i < NR; i++) begin
      logic [39:0] d = m_cfg[i];
      logic        m;
      if (d[4:0] >= 5'd27) m = 1'b1;
      else m = ((a >> (d[4:0] + 5)) == ({d[31:5], 5'b0} >> (d[4:0] + 5)));
      if (d[32] && m) begin
        e.hit = 1'b1; e.bg = 1'b0; e.idx = IW'(i);
        e.c = d[37]; e.wb = d[38]; e.sh = d[39];
        if (k == 2'd1)      e.pf = p ? !d[33] : !d[35];
        else if (k == 2'd2) e.pf = d[36] | (!p & !d[34]);
        else                e.pf = !p & !d[34];
      end
    end
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t act;
    act = '{res_hit, res_region, res_perm_fault, res_bg_fault, res_cacheable, res_write_back, res_shareable};
    checks++;
    if (!res_valid || act !== e) begin
      fails++;
      $display("FAIL %s: valid=%0b actual=%b expected=%b (hit,idx,pf,bg,c,wb,sh)", tag, res_valid, act, e);
    end
  endtask

  task automatic wr(input int i, input logic [39:0] d);
    cfg_we = 1'b1; cfg_idx = IW'(i); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (i < NR) m_cfg[i] = d;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic p, input string tag);
    exp_t e = model(a, k, p);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
    @(negedge clk);
    acc_valid = 1'b0;
    compare(e, tag);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2: watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) m_cfg[i] = '0;
    void'($urandom(32'd7215));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (res_valid !== 1'b0) begin
      fails++; $display("FAIL R1: res_valid actual=%0b expected=0", res_valid);
    end
    acc(32'h0000_0000, 2'd0, 1'b1, "R1 first access background");

    // R4: 128-byte region at 0x1000, user read, priv write, cacheable write-back
    wr(0, mk(32'h0000_1000, 5'd2, 1'b1, 4'b0011, 3'b011));
    acc(32'h0000_107F, 2'd0, 1'b0, "R4 last byte inside");
    acc(32'h0000_1080, 2'd0, 1'b0, "R4 first byte outside");
    acc(32'h0000_0FFF, 2'd0, 1'b0, "R4 byte below base");
    // R4: misaligned base ignored below size (covers 0x2000..0x20FF)
    wr(1, mk(32'h0000_2010, 5'd3, 1'b1, 4'b0111, 3'b100));
    acc(32'h0000_2000, 2'd1, 1'b0, "R4 misaligned base low bits dropped");
    // R4: smallest 32-byte region
    wr(2, mk(32'h0000_3020, 5'd0, 1'b1, 4'b0010, 3'b001));
    acc(32'h0000_303F, 2'd0, 1'b0, "R4 32-byte region end");
    acc(32'h0000_3040, 2'd0, 1'b0, "R4 32-byte region next");

    // R5: overlap, highest index wins
    wr(3, mk(32'h0000_0000, 5'd11, 1'b1, 4'b1111, 3'b000));
    wr(5, mk(32'h0000_1000, 5'd7, 1'b1, 4'b0011, 3'b101));
    acc(32'h0000_1040, 2'd0, 1'b0, "R5 three overlapping, region 5 wins");
    acc(32'h0000_1FFF, 2'd1, 1'b1, "R5 two overlapping edge");
    acc(32'h0000_8000, 2'd0, 1'b0, "R5 only region 3");
    wr(7, mk(32'h0000_1000, 5'd7, 1'b0, 4'b0000, 3'b111));
    acc(32'h0000_1100, 2'd0, 1'b0, "R5 disabled higher region ignored");

    // R7: permission rules
    acc(32'h0000_1100, 2'd1, 1'b0, "R7 user write denied");
    acc(32'h0000_1100, 2'd1, 1'b1, "R7 priv write allowed");
    wr(6, mk(32'h0000_4000, 5'd4, 1'b1, 4'b0000, 3'b010));
    acc(32'h0000_4000, 2'd0, 1'b1, "R7 priv read always allowed");
    acc(32'h0000_4000, 2'd0, 1'b0, "R7 user read denied");
    acc(32'h0000_4000, 2'd1, 1'b1, "R7 priv write denied");
    acc(32'h0000_4000, 2'd3, 1'b0, "R7 kind 3 behaves as read");
    // R8: execute rules
    wr(8, mk(32'h0000_5000, 5'd4, 1'b1, 4'b1111, 3'b000));
    acc(32'h0000_5004, 2'd2, 1'b1, "R8 forbidden execute faults");
    acc(32'h0000_4004, 2'd2, 1'b1, "R8 priv execute allowed");
    acc(32'h0000_4004, 2'd2, 1'b0, "R8 user execute needs user read");

    // R3: out-of-range index ignored
    wr(13, mk(32'h0000_0000, 5'd27, 1'b1, 4'b1111, 3'b111));
    acc(32'h9000_0000, 2'd0, 1'b1, "R3 write to index 13 ignored");
    // R3: same-edge write not yet visible
    begin
      exp_t e = model(32'hA000_0000, 2'd0, 1'b1);
      cfg_we = 1'b1; cfg_idx = 4'd11; cfg_data = mk(32'h0, 5'd27, 1'b1, 4'b1110, 3'b111);
      acc_valid = 1'b1; acc_addr = 32'hA000_0000; acc_kind = 2'd0; acc_priv = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; acc_valid = 1'b0;
      m_cfg[11] = cfg_data;
      compare(e, "R3 same-edge access sees old config");
    end
    // R10 / R4: top index covers whole space and wins everywhere
    acc(32'hA000_0000, 2'd0, 1'b1, "R10 region 11 whole space");
    acc(32'h0000_1040, 2'd2, 1'b0, "R10 region 11 beats all");
    acc(32'hFFFF_FFFF, 2'd1, 1'b0, "R9 attributes of top region");

    // R2: idle cycle gives no result
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      fails++; $display("FAIL R2: idle res_valid actual=%0b expected=0", res_valid);
    end

    // Random phase: R4 R5 R7 R8 R9
    for (int i = 0; i < NR; i++)
      wr(i, mk($urandom & 32'h0000_FFE0, 5'($urandom % 11), ($urandom % 4) != 0,
               4'($urandom), 3'($urandom)));
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 16 == 0)
        wr(int'($urandom % 16), mk($urandom & 32'h0000_FFE0, 5'($urandom % 11),
                                   ($urandom % 4) != 0, 4'($urandom), 3'($urandom)));
      acc(($urandom % 8 == 0) ? $urandom : ($urandom & 32'h0001_FFFF),
          2'($urandom), 1'($urandom), "R9 random access");
    end

    // R1: reset again clears regions
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NR; i++) m_cfg[i] = '0;
    checks++;
    if (res_valid !== 1'b0) begin
      fails++; $display("FAIL R1: res_valid after reset actual=%0b expected=0", res_valid);
    end
    acc(32'h0000_1040, 2'd0, 1'b1, "R1 regions cleared by reset");

    finish_run();
  end

endmodule